// File: doc/BRIEF.md
# Register-Mapped Reconfiguration Port Bridge

This block is a memory-mapped register slave. Software uses it to reach the 16-bit dynamic reconfiguration port of a clock-synthesis primitive. Software writes the control word once, and that write launches one complete port transaction, either a read or a write. Software then polls a status word. That word carries a busy flag next to the 16 bits returned by the last port read.

Two further registers drive the primitive's side-band pins. The first holds a soft-reset bit and a primitive-enable bit. The second picks one of two reference clocks. The register bus is a single-cycle write strobe with a combinational read path. The port side drives one enable pulse per transaction and waits for the primitive's ready pulse.

Top module: `drp_bridge`

## Requirements
- R1: After reset every register reads zero, busy and the error flag are clear, and `prim_en`, `soft_rst`, `ref_sel`, `drp_en` and `drp_we` are low.
- R2: A write to offset 0x40 stores bits 1:0. Bit 0 drives `soft_rst`, bit 1 drives `prim_en`, and a read of 0x40 returns both bits in those positions.
- R3: A write to offset 0x44 stores bit 0 as the reference index. It drives `ref_sel` and reads back in bit 0 of 0x44.
- R4: A write to offset 0x70 with bit 29 set and bit 28 clear, made while idle, starts a port write. In the next cycle `drp_en` and `drp_we` are high for exactly one cycle. `drp_addr` carries control bits 22:16 and `drp_di` carries bits 15:0.
- R5: A write to 0x70 with bits 29 and 28 both set, made while idle, starts a port read. It gives a one-cycle `drp_en` with `drp_we` low. The `drp_do` value seen with `drp_rdy` appears in status bits 15:0 (offset 0x74) from the next cycle on.
- R6: Status bit 16 (busy) rises in the cycle after an accepted control write. It falls in the cycle after `drp_rdy` is sampled high, and it stays high until then.
- R7: A control write with bit 29 set that arrives while busy is ignored: no `drp_en` pulse follows. It sets the sticky error flag in status bit 17.
- R8: A write to 0x74 with bit 17 set clears the error flag. A write to 0x74 with bit 17 clear leaves the flag unchanged.
- R9: A control write with bit 29 clear starts no transaction and leaves busy clear.
- R10: A `drp_rdy` pulse while not busy changes neither busy nor the read data.
- R11: Reads of 0x70 and of any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| soft_rst | output | 1 | Soft-reset enable to the primitive |
| prim_en | output | 1 | Primitive enable |
| ref_sel | output | 1 | Reference clock index |
| drp_en | output | 1 | Port transaction enable pulse |
| drp_we | output | 1 | Port write enable, high only with `drp_en` on writes |
| drp_addr | output | 7 | Port register address |
| drp_di | output | 16 | Port write data |
| drp_do | input | 16 | Port read data, valid with `drp_rdy` |
| drp_rdy | input | 1 | Port transaction complete pulse |

## Verification
The bench builds the bridge with its default widths: an 8-bit offset, a 7-bit port address and 16-bit port data. With these widths it can drive the top port address 0x7F and all-ones data words through the bit-packed control field. Its responder model changes its ready latency at run time between one and five cycles. A latency of one cycle places ready directly after the enable pulse. Longer latencies leave room for control writes that collide with a busy transaction and for status polls in the middle of a transaction.

// File: rtl/drp_bridge.sv
module drp_bridge #(
  parameter int ADDR_W = 8,
  parameter int DRP_AW = 7,
  parameter int DRP_DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              soft_rst,
  output logic              prim_en,
  output logic              ref_sel,
  output logic              drp_en,
  output logic              drp_we,
  output logic [DRP_AW-1:0] drp_addr,
  output logic [DRP_DW-1:0] drp_di,
  input  logic [DRP_DW-1:0] drp_do,
  input  logic              drp_rdy
);
  localparam logic [ADDR_W-1:0] OFF_RST  = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] OFF_SEL  = ADDR_W'(8'h44);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(8'h70);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(8'h74);
  localparam int STB_BIT  = 29;
  localparam int RD_BIT   = 28;
  localparam int ADR_LSB  = 16;
  localparam int BUSY_BIT = DRP_DW;
  localparam int ERR_BIT  = DRP_DW + 1;
  localparam int PAD_W    = 32 - DRP_DW - 2;

  logic [1:0]        rst_q;
  logic              sel_q;
  logic              busy_q;
  logic              err_q;
  logic              rd_q;
  logic              en_q;
  logic              we_q;
  logic [DRP_AW-1:0] addr_q;
  logic [DRP_DW-1:0] di_q;
  logic [DRP_DW-1:0] rdat_q;

  wire ctrl_hit = bus_wr && (bus_addr == OFF_CTRL) && bus_wdata[STB_BIT];
  wire accept   = ctrl_hit && !busy_q;
  wire done     = busy_q && drp_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q  <= '0;
      sel_q  <= 1'b0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      rd_q   <= 1'b0;
      en_q   <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      di_q   <= '0;
      rdat_q <= '0;
    end else begin
      en_q <= 1'b0;
      we_q <= 1'b0;
      if (done) begin
        busy_q <= 1'b0;
        if (rd_q) rdat_q <= drp_do;
      end
      if (accept) begin
        busy_q <= 1'b1;
        en_q   <= 1'b1;
        we_q   <= ~bus_wdata[RD_BIT];
        rd_q   <= bus_wdata[RD_BIT];
        addr_q <= bus_wdata[ADR_LSB +: DRP_AW];
        di_q   <= bus_wdata[DRP_DW-1:0];
      end else if (ctrl_hit) begin
        err_q <= 1'b1;
      end
      if (bus_wr && bus_addr == OFF_RST) rst_q <= bus_wdata[1:0];
      if (bus_wr && bus_addr == OFF_SEL) sel_q <= bus_wdata[0];
      if (bus_wr && bus_addr == OFF_STAT && bus_wdata[ERR_BIT]) err_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFF_RST)       bus_rdata[1:0] = rst_q;
    else if (bus_addr == OFF_SEL)  bus_rdata[0] = sel_q;
    else if (bus_addr == OFF_STAT) bus_rdata = {{PAD_W{1'b0}}, err_q, busy_q, rdat_q};
  end

  assign soft_rst = rst_q[0];
  assign prim_en  = rst_q[1];
  assign ref_sel  = sel_q;
  assign drp_en   = en_q;
  assign drp_we   = we_q;
  assign drp_addr = addr_q;
  assign drp_di   = di_q;
endmodule

// File: rtl/drp_bridge_chk.sv
module drp_bridge_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic drp_en,
  input logic drp_we,
  input logic drp_rdy
);
  // R4
  we_with_en_chk: assert property (@(posedge clk) disable iff (!rst_n) drp_we |-> drp_en);
  // R4
  en_single_chk: assert property (@(posedge clk) disable iff (!rst_n) drp_en |=> !drp_en);
  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> drp_en);
  // R6
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && drp_rdy) |=> !busy);
  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && !drp_rdy) |=> busy);
  // R7
  en_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) drp_en |-> busy);
endmodule

bind drp_bridge drp_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_q),
  .drp_en(drp_en), .drp_we(drp_we), .drp_rdy(drp_rdy)
);

// File: tb/sim_drp_bridge.sv
module sim_drp_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic soft_rst, prim_en, ref_sel, drp_en, drp_we;
  logic [6:0] drp_addr;
  logic [15:0] drp_di;
  logic [15:0] drp_do = '0;
  logic drp_rdy = 1'b0;

  always #2.5 clk = ~clk;

  drp_bridge u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .soft_rst(soft_rst),
    .prim_en(prim_en), .ref_sel(ref_sel), .drp_en(drp_en), .drp_we(drp_we),
    .drp_addr(drp_addr), .drp_di(drp_di), .drp_do(drp_do), .drp_rdy(drp_rdy)
  );

  int checks = 0, errors = 0, cycles = 0;
  logic [1:0] m_rst; logic m_sel, m_busy, m_err, m_rd, m_en, m_we;
  logic [6:0] m_addr; logic [15:0] m_di, m_data;
  logic [15:0] mem [128];
  int lat = 1, rcnt = 0; logic [6:0] r_a; logic r_w; logic [15:0] r_d;
  logic stray = 1'b0;
  logic p_rst, p_wr, p_rdy; logic [7:0] p_addr; logic [31:0] p_wd; logic [15:0] p_do;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mread(input logic [7:0] a);
    case (a)
      8'h40: return {30'b0, m_rst};
      8'h44: return {31'b0, m_sel};
      8'h74: return {14'b0, m_err, m_busy, m_data};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_step();
    logic ob;
    ob = m_busy;
    if (!p_rst) begin
      m_rst = 0; m_sel = 0; m_busy = 0; m_err = 0; m_rd = 0; m_en = 0; m_we = 0;
      m_addr = 0; m_di = 0; m_data = 0;
      return;
    end
    m_en = 0; m_we = 0;
    if (p_rdy && ob) begin m_busy = 0; if (m_rd) m_data = p_do; end
    if (p_wr) begin
      case (p_addr)
        8'h40: m_rst = p_wd[1:0];
        8'h44: m_sel = p_wd[0];
        8'h70: if (p_wd[29]) begin
          if (ob) m_err = 1;
          else begin
            m_busy = 1; m_en = 1; m_we = ~p_wd[28]; m_rd = p_wd[28];
            m_addr = p_wd[22:16]; m_di = p_wd[15:0];
          end
        end
        8'h74: if (p_wd[17]) m_err = 0;
        default: ;
      endcase
    end
  endtask

  task automatic tick();
    logic [31:0] exp;
    p_rst = rst_n; p_wr = bus_wr; p_addr = bus_addr; p_wd = bus_wdata;
    p_rdy = drp_rdy; p_do = drp_do;
    @(posedge clk);
    @(negedge clk);
    cycles++;
    model_step();
    chk(drp_en == m_en, "R4 drp_en", 32'(drp_en), 32'(m_en));
    chk(drp_we == (m_en & m_we), "R4 drp_we", 32'(drp_we), 32'(m_en & m_we));
    if (m_en) begin
      chk(drp_addr == m_addr, "R4 drp_addr", 32'(drp_addr), 32'(m_addr));
      chk(drp_di == m_di, "R4 drp_di", 32'(drp_di), 32'(m_di));
    end
    chk(prim_en == m_rst[1] && soft_rst == m_rst[0], "R2 pins", {soft_rst, prim_en}, {m_rst[0], m_rst[1]});
    chk(ref_sel == m_sel, "R3 ref_sel", 32'(ref_sel), 32'(m_sel));
    exp = mread(bus_addr);
    chk(bus_rdata == exp, "R6 rdata", bus_rdata, exp);
    drp_rdy = 0;
    if (drp_en) begin rcnt = lat; r_a = drp_addr; r_w = drp_we; r_d = drp_di; end
    if (rcnt > 0) begin
      rcnt--;
      if (rcnt == 0) begin
        drp_rdy = 1;
        if (r_w) mem[r_a] = r_d; else drp_do = mem[r_a];
      end
    end
    if (stray) begin drp_rdy = 1; drp_do = 16'hDEAD; end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 0;
  endtask

  task automatic wait_idle();
    bus_addr = 8'h74;
    tick();
    for (int i = 0; i < 50 && bus_rdata[16]; i++) tick();
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 16'h0;
    forever begin
      @(posedge clk);
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    tick(); tick();
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      bus_addr = (a == 0) ? 8'h40 : (a == 1) ? 8'h44 : (a == 2) ? 8'h70 : 8'h74;
      #1 chk(bus_rdata == 0, "R1 reg zero", bus_rdata, 0);
    end
    chk({prim_en, soft_rst, ref_sel, drp_en, drp_we} == 0, "R1 pins", {prim_en, soft_rst, ref_sel, drp_en, drp_we}, 0);
    rst_n = 1; tick();
    // R2
    wr(8'h40, 32'hFFFF_FFFE); bus_addr = 8'h40; tick();
    chk(bus_rdata == 32'h2 && prim_en && !soft_rst, "R2 enable", bus_rdata, 32'h2);
    wr(8'h40, 32'h1); tick(); wr(8'h40, 32'h3); tick();
    // R3
    wr(8'h44, 32'h1); bus_addr = 8'h44; tick();
    chk(ref_sel && bus_rdata == 1, "R3 select", bus_rdata, 1);
    wr(8'h44, 32'h0); tick();
    // R4 write then R5 read, latency 1
    wr(8'h70, 32'h2015_A5C3);
    chk(drp_en && drp_we && drp_addr == 7'h15 && drp_di == 16'hA5C3, "R4 write pulse", {drp_addr, drp_di}, {7'h15, 16'hA5C3});
    wait_idle();
    wr(8'h70, 32'h3015_0000);
    chk(drp_en && !drp_we, "R5 read pulse", 32'(drp_we), 0);
    wait_idle();
    chk(bus_rdata[15:0] == 16'hA5C3, "R5 read data", 32'(bus_rdata[15:0]), 32'hA5C3);
    // R6, R7 with latency 4
    lat = 4;
    wr(8'h70, 32'h207F_FFFF);
    bus_addr = 8'h74; #1 chk(bus_rdata[16] == 1, "R6 busy set", bus_rdata, 32'h1_0000);
    wr(8'h70, 32'h2011_1234);
    chk(!drp_en, "R7 ignored pulse", 32'(drp_en), 0);
    bus_addr = 8'h74; #1 chk(bus_rdata[17] == 1, "R7 sticky", bus_rdata, 32'h3_0000);
    wait_idle();
    chk(bus_rdata[17:16] == 2'b10, "R7 sticky after idle", 32'(bus_rdata[17:16]), 2);
    // R8
    wr(8'h74, 32'h0); bus_addr = 8'h74; tick();
    chk(bus_rdata[17] == 1, "R8 keep", bus_rdata, 32'h2_0000);
    wr(8'h74, 32'h2_0000); bus_addr = 8'h74; tick();
    chk(bus_rdata[17] == 0, "R8 clear", bus_rdata, 0);
    wr(8'h70, 32'h307F_0000); wait_idle();
    chk(bus_rdata[15:0] == 16'hFFFF, "R5 top address", 32'(bus_rdata[15:0]), 32'hFFFF);
    // R9
    wr(8'h70, 32'h1015_0000);
    chk(!drp_en, "R9 no start", 32'(drp_en), 0);
    bus_addr = 8'h74; #1 chk(bus_rdata[16] == 0, "R9 idle", bus_rdata, 0);
    // R10
    stray = 1; tick(); stray = 0; tick(); tick();
    chk(bus_rdata[16:0] == 17'h0FFFF, "R10 stray ready", bus_rdata, 32'hFFFF);
    // R11
    bus_addr = 8'h70; #1 chk(bus_rdata == 0, "R11 ctrl reads zero", bus_rdata, 0);
    bus_addr = 8'h10; #1 chk(bus_rdata == 0, "R11 unmapped", bus_rdata, 0);
    // mixed traffic, varying latency, back-to-back collisions
    for (int n = 0; n < 300; n++) begin
      logic [31:0] w;
      lat = 1 + ($urandom % 5);
      w = $urandom;
      w[29] = ($urandom % 8) != 0;
      case ($urandom % 6)
        0: wr(8'h40, w);
        1: wr(8'h44, w);
        2: wr(8'h74, w);
        default: wr(8'h70, w);
      endcase
      bus_addr = 8'h74;
      if ($urandom % 2) wait_idle(); else tick();
    end
    wait_idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule